// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. Software-visible framing is supplied as an 8-bit line-control word on an input port. It selects the number of data bits, whether a parity bit is added and how it is formed, and whether one or two stop bits close each frame. It also selects how deep the transmit holding buffer is and whether the line is forced into a break condition. Bytes enter through a valid/ready push port. Timing comes from an external strobe, `bit_tick`, that pulses for one clock per bit period, so the baud-rate divider lives outside the block.

The line-control word is sampled only when a frame is about to begin. A frame already on the wire is never altered by a later change. The break request is likewise honoured only at that point, so a character being sent always completes before the line is held low. While the buffer is disabled as a FIFO it holds a single character. With the FIFO enabled it holds up to `DEPTH` characters. Consecutive queued characters are sent with no idle time between them.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `ser_out` is high and `in_ready` is high.
- R2: A frame is a low start bit, then the data bits least-significant first, then the optional parity bit, then high stop bits. A character already queued starts in the bit period right after the previous frame's last stop bit.
- R3: `line_ctrl[6:5]` selects the data-bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected count are neither sent nor counted for parity.
- R4: With `line_ctrl[1]` set, one parity bit follows the data. If `line_ctrl[2]` is 0 the parity is odd (data plus parity holds an odd number of ones). If `line_ctrl[2]` is 1 the parity is even.
- R5: With `line_ctrl[7]` and `line_ctrl[1]` both set, the parity bit is the inverse of `line_ctrl[2]`. With `line_ctrl[1]` clear, `line_ctrl[7]` has no effect and no parity bit is sent.
- R6: `line_ctrl[3]` set appends two stop bits to each frame. Clear appends one.
- R7: While `line_ctrl[0]` is set, the line is held low continuously. This starts only after the frame in progress has ended. Queued characters are held back, not sent. After the bit is cleared, the line goes high for at least one bit period before the next frame.
- R8: With `line_ctrl[4]` clear, the buffer holds one character. With it set, the buffer holds `DEPTH` (default 16) characters in arrival order. `in_ready` is low whenever the buffer is at its current capacity.
- R9: The framing fields are taken when a frame starts. Changes made during a frame apply from the next frame.
- R10: `busy` is high while a frame or a break is on the line, or the buffer holds a character.
- R11: `ser_out` changes only in the clock cycle after one in which `bit_tick` was high, so every bit lasts one whole tick interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| line_ctrl | input | 8 | Framing, buffer-mode and break controls |
| in_valid | input | 1 | Character offered for transmission |
| in_data | input | 8 | Character to transmit |
| in_ready | output | 1 | Buffer can accept a character this cycle |
| ser_out | output | 1 | Serial line, idles high |
| busy | output | 1 | Transmission, break or buffered data pending |

## Verification
The bench decodes the line at mid-bit and compares whole frame streams. It sends a byte whose upper bits would change the parity if word length were ignored. It sends stick-parity values that differ from the computed parity. It sends back-to-back frames in which a miscounted stop bit or idle gap shows up as a misplaced start bit. It also changes the line-control word mid-frame, so a design that applies framing immediately garbles the frame in flight. Break is asserted during a frame: a design that cuts the frame short, or sends the character queued behind the break, produces wrong bits. A design that restarts without a mark period also fails. The buffer is filled while a break is in progress. A FIFO that is too shallow, is wrongly ordered, or ignores the single-entry mode is exposed through `in_ready` and the order of the drained frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CHAR_W = 8;

  // Field order matches the line-control bit positions (bit 7 first).
  typedef struct packed {
    logic       stick;
    logic [1:0] wlen;
    logic       fifo_on;
    logic       two_stop;
    logic       even;
    logic       par_on;
    logic       brk;
  } line_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_BREAK
  } tx_state_e;

  // Index of the last data bit for a word-length code (5..8 bits).
  function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
    return 3'd4 + {1'b0, wlen};
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_on,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_pop,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_avail,
  output logic [$clog2(DEPTH+1)-1:0] fill
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CHAR_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     fill_q, fill_d;
  logic [CW-1:0]     cap;
  logic              do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Single-entry mode reuses the same storage with a capacity of one.
  assign cap      = fifo_on ? CW'(DEPTH) : CW'(1);
  assign wr_ready = (fill_q < cap);
  assign rd_avail = (fill_q != '0);
  assign rd_data  = mem_q[rd_ptr_q];
  assign fill     = fill_q;

  assign do_wr = wr_valid & wr_ready;
  assign do_rd = rd_pop & rd_avail;

  always_comb begin
    wr_ptr_d = do_wr ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_rd ? bump(rd_ptr_q) : rd_ptr_q;
    unique case ({do_wr, do_rd})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else if (do_wr || do_rd) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem_q[wr_ptr_q] <= wr_data;
    end
  end

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
(
  input  logic [CHAR_W-1:0] data,
  input  logic [1:0]        wlen,
  input  logic              even,
  input  logic              stick,
  output logic              pbit
);

  logic [CHAR_W-1:0] kept;
  logic [2:0]        top_idx;
  logic              ones_odd;

  assign top_idx = last_bit_idx(wlen);

  for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_mask
    assign kept[gi] = data[gi] & (3'(gi) <= top_idx);
  end

  assign ones_odd = ^kept;

  // Stick: fixed level opposite to the even select. Otherwise even/odd sense.
  assign pbit = stick ? ~even : (even ? ones_odd : ~ones_odd);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              brk_req,
  input  logic [1:0]        wlen,
  input  logic              par_on,
  input  logic              two_stop,
  input  logic              par_bit,
  input  logic [CHAR_W-1:0] head_data,
  input  logic              head_avail,
  output logic              take,
  output logic              ser_out,
  output logic              active,
  output logic              in_break
);

  tx_state_e         st_q, st_d;
  logic [1:0]        wlen_q, wlen_d;
  logic              par_on_q, par_on_d;
  logic              stop2_q, stop2_d;
  logic              pbit_q, pbit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [2:0]        cnt_q, cnt_d;
  logic              out_q, out_d;
  logic              boundary;

  always_comb begin
    st_d     = st_q;
    wlen_d   = wlen_q;
    par_on_d = par_on_q;
    stop2_d  = stop2_q;
    pbit_d   = pbit_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    out_d    = out_q;
    take     = 1'b0;
    boundary = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        boundary = tick;
      end
      ST_START: begin
        if (tick) begin
          st_d  = ST_DATA;
          cnt_d = '0;
          out_d = sh_q[0];
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (cnt_q == last_bit_idx(wlen_q)) begin
            if (par_on_q) begin
              st_d  = ST_PAR;
              out_d = pbit_q;
            end else begin
              st_d  = ST_STOP1;
              out_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 3'd1;
            sh_d  = sh_q >> 1;
            out_d = sh_q[1];
          end
        end
      end
      ST_PAR: begin
        if (tick) begin
          st_d  = ST_STOP1;
          out_d = 1'b1;
        end
      end
      ST_STOP1: begin
        if (tick) begin
          if (stop2_q) begin
            st_d = ST_STOP2;
          end else begin
            boundary = 1'b1;
          end
        end
      end
      ST_STOP2: begin
        boundary = tick;
      end
      ST_BREAK: begin
        if (tick && !brk_req) begin
          st_d  = ST_IDLE;
          out_d = 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        out_d = 1'b1;
      end
    endcase

    // Frame boundary: break wins, then a queued character, else idle.
    if (boundary) begin
      if (brk_req) begin
        st_d  = ST_BREAK;
        out_d = 1'b0;
      end else if (head_avail) begin
        st_d     = ST_START;
        out_d    = 1'b0;
        take     = 1'b1;
        wlen_d   = wlen;
        par_on_d = par_on;
        stop2_d  = two_stop;
        pbit_d   = par_bit;
        sh_d     = head_data;
      end else begin
        st_d  = ST_IDLE;
        out_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wlen_q   <= '0;
      par_on_q <= 1'b0;
      stop2_q  <= 1'b0;
      pbit_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      out_q    <= 1'b1;
    end else if (tick) begin
      st_q     <= st_d;
      wlen_q   <= wlen_d;
      par_on_q <= par_on_d;
      stop2_q  <= stop2_d;
      pbit_q   <= pbit_d;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      out_q    <= out_d;
    end
  end

  assign ser_out  = out_q;
  assign active   = (st_q != ST_IDLE);
  assign in_break = (st_q == ST_BREAK);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic [7:0] line_ctrl,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       ser_out,
  output logic       busy
);

  localparam int CW = $clog2(DEPTH + 1);

  line_cfg_t         cfg;
  logic [CHAR_W-1:0] head_data;
  logic              head_avail;
  logic              take;
  logic              par_bit;
  logic              framer_active;
  logic              brk_active;
  logic [CW-1:0]     buf_fill;

  assign cfg = line_cfg_t'(line_ctrl);

  uart_tx_hold #(
    .DEPTH (DEPTH)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_on  (cfg.fifo_on),
    .wr_valid (in_valid),
    .wr_data  (in_data),
    .wr_ready (in_ready),
    .rd_pop   (take),
    .rd_data  (head_data),
    .rd_avail (head_avail),
    .fill     (buf_fill)
  );

  uart_tx_parity u_parity (
    .data  (head_data),
    .wlen  (cfg.wlen),
    .even  (cfg.even),
    .stick (cfg.stick),
    .pbit  (par_bit)
  );

  uart_tx_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bit_tick),
    .brk_req    (cfg.brk),
    .wlen       (cfg.wlen),
    .par_on     (cfg.par_on),
    .two_stop   (cfg.two_stop),
    .par_bit    (par_bit),
    .head_data  (head_data),
    .head_avail (head_avail),
    .take       (take),
    .ser_out    (ser_out),
    .active     (framer_active),
    .in_break   (brk_active)
  );

  assign busy = framer_active | head_avail;

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       fifo_on,
  input logic                       push_valid,
  input logic                       push_ready,
  input logic                       line,
  input logic                       busy,
  input logic                       brk_on,
  input logic [$clog2(DEPTH+1)-1:0] fill
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> push_ready);

  assert_bit_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(line));

  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |-> !line);

  assert_break_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |-> busy);

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> busy);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  assert_single_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && push_valid && push_ready) |=> (!push_ready || fifo_on));

endmodule

bind uart_frame_tx uart_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (bit_tick),
  .fifo_on    (line_ctrl[4]),
  .push_valid (in_valid),
  .push_ready (in_ready),
  .line       (ser_out),
  .busy       (busy),
  .brk_on     (brk_active),
  .fill       (buf_fill)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  localparam int DIV = 8;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic [7:0] line_ctrl;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       ser_out;
  logic       busy;

  int total;
  int bad;
  logic exp_v [0:255];
  int exp_n;

  uart_frame_tx dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .line_ctrl (line_ctrl),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .ser_out   (ser_out),
    .busy      (busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    bit_tick = 1'b0;
    forever begin
      repeat (DIV - 1) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clr();
    exp_n = 0;
  endtask

  task automatic add_bit(input logic b);
    exp_v[exp_n] = b;
    exp_n++;
  endtask

  // Expected frame built from the requirements (R2..R6).
  task automatic add_frame(input logic [7:0] d, input logic [7:0] lc);
    int nb;
    int ones;
    logic p;
    nb = 5 + int'(lc[6:5]);
    ones = 0;
    add_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      add_bit(d[i]);
      ones += int'(d[i]);
    end
    if (lc[1]) begin
      if (lc[7])      p = ~lc[2];
      else if (lc[2]) p = (ones % 2 == 1);
      else            p = (ones % 2 == 0);
      add_bit(p);
    end
    add_bit(1'b1);
    if (lc[3]) add_bit(1'b1);
  endtask

  // Decode exp_n bits at mid-bit starting from the next start bit.
  task automatic grab_check(input string tag);
    int mism;
    int first;
    logic f_act;
    logic f_exp;
    mism = 0;
    first = -1;
    f_act = 1'b0;
    f_exp = 1'b0;
    while (ser_out !== 1'b1) @(negedge clk);
    while (ser_out !== 1'b0) @(negedge clk);
    repeat (DIV / 2) @(negedge clk);
    for (int i = 0; i < exp_n; i++) begin
      if (i > 0) repeat (DIV) @(negedge clk);
      if (ser_out !== exp_v[i]) begin
        mism++;
        if (first < 0) begin
          first = i;
          f_act = ser_out;
          f_exp = exp_v[i];
        end
      end
    end
    total++;
    if (mism != 0) begin
      bad++;
      $display("FAIL %s: bit %0d actual=%0b expected=%0b (%0d bits wrong)",
               tag, first, f_act, f_exp, mism);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    repeat (DIV + 2) @(negedge clk);
    chk(busy == 1'b0, tag, int'(busy), 0);
    chk(ser_out == 1'b1, tag, int'(ser_out), 1);
  endtask

  task automatic t_reset();
    chk(ser_out == 1'b1, "R1 reset line high", int'(ser_out), 1);
    chk(busy == 1'b0, "R1 reset not busy", int'(busy), 0);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
  endtask

  task automatic t_basic();
    clr();
    add_frame(8'hA5, 8'h60);
    add_frame(8'h3C, 8'h60);
    line_ctrl = 8'h60;
    fork
      begin
        push(8'hA5);
        chk(busy == 1'b1, "R10 busy after push", int'(busy), 1);
        push(8'h3C);
      end
      grab_check("R2 R3 8N1 back-to-back frames");
    join
    wait_idle("R10 R1 idle after 8N1");
  endtask

  task automatic t_wlen();
    for (int wl = 0; wl < 3; wl++) begin
      logic [7:0] lc;
      lc = 8'(wl << 5) | 8'h06;
      clr();
      add_frame(8'hE6, lc);
      add_bit(1'b1);
      line_ctrl = lc;
      fork
        push(8'hE6);
        grab_check("R3 R4 short word with even parity");
      join
      wait_idle("R3 idle after short word");
    end
  endtask

  task automatic t_odd();
    clr();
    add_frame(8'h15, 8'h42);
    add_frame(8'h7F, 8'h42);
    line_ctrl = 8'h42;
    fork
      begin push(8'h15); push(8'h7F); end
      grab_check("R4 odd parity 7-bit");
    join
    wait_idle("R4 idle after odd parity");
  endtask

  task automatic t_stick();
    clr();
    add_frame(8'h01, 8'h82);
    line_ctrl = 8'h82;
    fork
      push(8'h01);
      grab_check("R5 stick parity forced high");
    join
    wait_idle("R5 idle");
    clr();
    add_frame(8'h07, 8'hA6);
    line_ctrl = 8'hA6;
    fork
      push(8'h07);
      grab_check("R5 stick parity forced low");
    join
    wait_idle("R5 idle");
    clr();
    add_frame(8'h55, 8'hE4);
    add_frame(8'h2A, 8'hE4);
    line_ctrl = 8'hE4;
    fork
      begin push(8'h55); push(8'h2A); end
      grab_check("R5 stick ignored without parity");
    join
    wait_idle("R5 idle");
  endtask

  task automatic t_two_stop();
    clr();
    add_frame(8'h96, 8'h68);
    add_frame(8'h0F, 8'h68);
    line_ctrl = 8'h68;
    fork
      begin push(8'h96); push(8'h0F); end
      grab_check("R6 two stop bits between frames");
    join
    wait_idle("R6 idle");
  endtask

  task automatic t_cfg_switch();
    clr();
    add_frame(8'h3C, 8'h60);
    add_frame(8'h5B, 8'h4E);
    line_ctrl = 8'h60;
    fork
      begin push(8'h3C); push(8'h5B); end
      grab_check("R9 framing changes at frame boundary");
      begin
        while (ser_out !== 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        line_ctrl = 8'h4E;
      end
    join
    wait_idle("R9 idle");
  endtask

  task automatic t_break();
    bit went_high;
    clr();
    add_frame(8'h81, 8'h60);
    for (int i = 0; i < 4; i++) add_bit(1'b0);
    line_ctrl = 8'h60;
    fork
      push(8'h81);
      grab_check("R7 break after frame completes");
      begin
        while (ser_out !== 1'b0) @(negedge clk);
        repeat (16) @(negedge clk);
        line_ctrl = 8'h61;
      end
    join
    push(8'h42);
    repeat (3 * DIV) @(negedge clk);
    chk(ser_out == 1'b0, "R7 queued char held during break", int'(ser_out), 0);
    chk(busy == 1'b1, "R10 busy during break", int'(busy), 1);
    line_ctrl = 8'h60;
    went_high = 1'b0;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (ser_out === 1'b1) begin
        went_high = 1'b1;
        break;
      end
    end
    chk(went_high, "R7 mark after break cleared", int'(went_high), 1);
    clr();
    add_frame(8'h42, 8'h60);
    grab_check("R7 held char sent after break");
    wait_idle("R7 idle");
  endtask

  task automatic t_depth();
    line_ctrl = 8'h71;
    repeat (3 * DIV) @(negedge clk);
    chk(ser_out == 1'b0, "R7 break from idle", int'(ser_out), 0);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk(in_ready == 1'b1, "R8 ready with 15 queued", int'(in_ready), 1);
      push(8'(i * 13 + 1));
    end
    chk(in_ready == 1'b0, "R8 fifo full at 16", int'(in_ready), 0);
    clr();
    for (int i = 0; i < 16; i++) add_frame(8'(i * 13 + 1), 8'h70);
    line_ctrl = 8'h70;
    grab_check("R8 fifo drains in order");
    wait_idle("R8 idle after drain");

    line_ctrl = 8'h61;
    repeat (3 * DIV) @(negedge clk);
    chk(in_ready == 1'b1, "R8 single-entry ready when empty", int'(in_ready), 1);
    push(8'h99);
    chk(in_ready == 1'b0, "R8 single-entry full after one", int'(in_ready), 0);
    clr();
    add_frame(8'h99, 8'h60);
    line_ctrl = 8'h60;
    grab_check("R8 single-entry char sent");
    wait_idle("R8 idle after single");
  endtask

  initial begin
    total = 0;
    bad = 0;
    exp_n = 0;
    rst_n = 1'b0;
    line_ctrl = 8'h60;
    in_valid = 1'b0;
    in_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wlen();
    t_odd();
    t_stick();
    t_two_stop();
    t_cfg_switch();
    t_break();
    t_depth();
    report();
  end

endmodule